// File: doc/BRIEF.md
# Timestamp and Pulse Timer Unit

This block keeps a wide free-running tick count, advanced once for every reference-rate clock enable (nominally a 19.2 MHz crystal rate brought into the system clock domain as a one-cycle strobe). Three coarse timestamps are taken from that count by shifting it right by a programmable amount. These are a logging stamp, a tag stamp and an address-translation stamp, each presented on 32 bits. The logging stamp can instead show an externally supplied legacy millisecond time base. Software typically programs shifts of 14, 14 and 24, which give steps of roughly 853 us, 853 us and 874 ms.

A programmable divider reduces the reference rate to a common timer clock. Software writes the ratio minus one, so 191 gives divide-by-192 and a 100 kHz timer pulse. The divider has its own enable bit. Software clears the enable, writes the new value, and then sets the enable in a second write. Three pulse generators count common timer pulses and each emits a one-cycle tick at its own granularity. Typical settings are 100 us for generator 0 and 1 ms for generators 1 and 2. Consumers of the ticks are outside this block.

Top module: `tpu_timer_unit`

## Requirements
- R1: After reset every configuration field is zero. The tag and translation stamps read zero, no tick is issued, and the logging stamp shows `legacy_ms_time`.
- R2: The base counter (CNT_W bits) increments by one on each clock edge where `ref_tick` is high and holds otherwise. With shift 0, a stamp equals the low 32 bits of the count.
- R3: The base counter wraps from all ones to zero.
- R4: Register 1 holds three 6-bit shift fields: logging shift in bits [5:0], tag shift in bits [13:8] and translation shift in bits [21:16]. Each stamp equals (count >> shift) truncated or zero-extended to 32 bits, and a shift of CNT_W or more gives zero.
- R5: Register 1 bit 7 is the logging select. At 1 the logging stamp is the shifted count. At 0 it is `legacy_ms_time`, following that input combinationally.
- R6: Register 0 bits [15:0] hold a divider value V, and bit 31 is the divider enable. While enabled, a common timer pulse occurs once every V+1 reference ticks.
- R7: While the divider enable is 0, no tick is issued on any generator, whatever the reference activity or the value written.
- R8: Setting the enable restarts the divider and all generator counters from zero. If enable is written at edge E and `ref_tick` is high from edge E+1, the first tick of a generator is visible after edge E+(V+1)*L+1, where L is its pulse count.
- R9: Register 2 holds a 3-bit granularity code per generator, in bits [4i+2:4i] for generator i. Codes 0..7 map to 1, 2, 5, 10, 100, 1000, 10000 and 65536 common pulses (10 us to 655.36 ms at 100 kHz). A generator ticks once every L common pulses.
- R10: The three generators run independently at their own granularities from the same common pulse.
- R11: A write to any address other than 0, 1 or 2 changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe at the reference (crystal) rate |
| legacy_ms_time | input | TS_W | Legacy millisecond time base for the logging stamp |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | 32 | Register write data |
| stamp_log | output | TS_W | Logging timestamp |
| stamp_tag | output | TS_W | Tag timestamp |
| stamp_xlat | output | TS_W | Translation timestamp |
| tick_out | output | NUM_PG | One-cycle tick per pulse generator |

## Verification
The bench measures the exact cycle of the first tick after enable and the tick count over fixed windows. A divider that reloads with V rather than V+1, or a generator that fires one pulse early, shifts both of these. It re-enables the divider after a partial count, which catches counters that are not cleared by the enable. It also runs the reference with the divider disabled and writes all ones to an unmapped address, where a leaky enable or a loose address decode would produce ticks or corrupt stamps. The counter is carried through its all-ones wrap, and shifts larger than the counter width are checked for a zero result.

// File: rtl/tpu_pkg.sv
// Shared constants for the timestamp and pulse timer unit: register
// addresses, field positions and the granularity code table.
// Assumes generator fields are 4 bits apart in the granularity register.
package tpu_pkg;

    localparam int unsigned REG_DIV   = 0;
    localparam int unsigned REG_STAMP = 1;
    localparam int unsigned REG_GRAN  = 2;

    localparam int unsigned SHIFT_W   = 6;
    localparam int unsigned GSEL_W    = 3;
    localparam int unsigned NUM_STAMP = 3;

    localparam int unsigned STAMP_LOG  = 0;
    localparam int unsigned STAMP_TAG  = 1;
    localparam int unsigned STAMP_XLAT = 2;

    localparam int unsigned LOG_SHIFT_LSB  = 0;
    localparam int unsigned LOG_SEL_BIT    = 7;
    localparam int unsigned TAG_SHIFT_LSB  = 8;
    localparam int unsigned XLAT_SHIFT_LSB = 16;
    localparam int unsigned DIV_EN_BIT     = 31;
    localparam int unsigned GRAN_STRIDE    = 4;

    typedef enum logic [GSEL_W-1:0] {
        GRAN_10US   = 3'd0,
        GRAN_20US   = 3'd1,
        GRAN_50US   = 3'd2,
        GRAN_100US  = 3'd3,
        GRAN_1MS    = 3'd4,
        GRAN_10MS   = 3'd5,
        GRAN_100MS  = 3'd6,
        GRAN_655MS  = 3'd7
    } gran_code_e;

    // Number of common-clock pulses per tick for a granularity code.
    function automatic int unsigned gran_pulses(input logic [GSEL_W-1:0] code);
        case (gran_code_e'(code))
            GRAN_10US:  return 1;
            GRAN_20US:  return 2;
            GRAN_50US:  return 5;
            GRAN_100US: return 10;
            GRAN_1MS:   return 100;
            GRAN_10MS:  return 1000;
            GRAN_100MS: return 10000;
            default:    return 65536;
        endcase
    endfunction

endpackage

// File: rtl/tpu_cfg_regs.sv
// Configuration register file for the timer unit. Takes single-cycle
// writes and splits them into the divider, stamp and granularity fields.
// Assumes writes are full 32-bit words; unmapped addresses are dropped.
module tpu_cfg_regs
    import tpu_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned NUM_PG = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [31:0]                       wr_data,
    output logic [DIV_W-1:0]                  div_val,
    output logic                              div_en,
    output logic                              log_sel,
    output logic [NUM_STAMP-1:0][SHIFT_W-1:0] shifts,
    output logic [NUM_PG-1:0][GSEL_W-1:0]     gsel
);

    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(REG_DIV);
    localparam logic [ADDR_W-1:0] A_STAMP = ADDR_W'(REG_STAMP);
    localparam logic [ADDR_W-1:0] A_GRAN  = ADDR_W'(REG_GRAN);

    logic hit_div, hit_stamp, hit_gran;

    // Address decode for the three registers.
    always_comb begin
        hit_div   = wr_en && (wr_addr == A_DIV);
        hit_stamp = wr_en && (wr_addr == A_STAMP);
        hit_gran  = wr_en && (wr_addr == A_GRAN);
    end

    // Divider value and enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_val <= '0;
            div_en  <= 1'b0;
        end else if (hit_div) begin
            div_val <= wr_data[DIV_W-1:0];
            div_en  <= wr_data[DIV_EN_BIT];
        end
    end

    // Stamp shift and logging select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shifts  <= '0;
            log_sel <= 1'b0;
        end else if (hit_stamp) begin
            shifts[STAMP_LOG]  <= wr_data[LOG_SHIFT_LSB  +: SHIFT_W];
            shifts[STAMP_TAG]  <= wr_data[TAG_SHIFT_LSB  +: SHIFT_W];
            shifts[STAMP_XLAT] <= wr_data[XLAT_SHIFT_LSB +: SHIFT_W];
            log_sel            <= wr_data[LOG_SEL_BIT];
        end
    end

    // Granularity select per pulse generator.
    generate
        for (genvar g = 0; g < NUM_PG; g++) begin : g_gsel
            // Holds the code of generator g.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gsel[g] <= '0;
                else if (hit_gran)
                    gsel[g] <= wr_data[g*GRAN_STRIDE +: GSEL_W];
            end
        end
    endgenerate

    // An unmapped write must leave every field alone.
    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_div && !hit_stamp && !hit_gran)
        |=> ($stable(div_val) && $stable(div_en) && $stable(shifts)
             && $stable(log_sel) && $stable(gsel))) else $error("unmapped write"); // R11

endmodule

// File: rtl/tpu_base_counter.sv
// Wide free-running tick counter advanced by the reference-rate enable.
// Assumes ref_tick is already a one-cycle strobe in the clk domain.
module tpu_base_counter #(
    parameter int unsigned CNT_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    output logic [CNT_W-1:0] count
);

    // Count reference ticks, wrapping naturally at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (ref_tick)
            count <= count + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> (count == CNT_W'($past(count) + 1'b1))) else $error("count step"); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(count)) else $error("count hold"); // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && (&count)) |=> (count == '0)) else $error("count wrap"); // R3

endmodule

// File: rtl/tpu_xo_divider.sv
// Divides the reference-rate enable into the common timer pulse.
// The programmed value is the ratio minus one; while disabled the
// counter sits at zero and no pulse is produced.
module tpu_xo_divider #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             div_en,
    input  logic [DIV_W-1:0] div_val,
    output logic             com_pulse
);

    logic [DIV_W-1:0] div_cnt;
    logic             at_end;

    // Terminal count reached (>= guards against a smaller new value).
    always_comb at_end = (div_cnt >= div_val);

    // Divider counter and registered common pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !div_en) begin
            div_cnt   <= '0;
            com_pulse <= 1'b0;
        end else if (ref_tick) begin
            com_pulse <= at_end;
            div_cnt   <= at_end ? '0 : div_cnt + 1'b1;
        end else begin
            com_pulse <= 1'b0;
        end
    end

    AST_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |=> !com_pulse) else $error("pulse while disabled"); // R7
    AST_DIV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        com_pulse |-> ($past(ref_tick) && $past(div_en))) else $error("pulse source"); // R6

endmodule

// File: rtl/tpu_pulse_gen.sv
// One pulse generator: counts common timer pulses and issues a
// one-cycle tick every L pulses, L chosen by a granularity code.
// Assumes the count is cleared whenever the divider is disabled.
module tpu_pulse_gen
    import tpu_pkg::*;
#(
    parameter int unsigned PG_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_en,
    input  logic              com_pulse,
    input  logic [GSEL_W-1:0] gsel,
    output logic              tick
);

    logic [PG_W-1:0] pg_cnt;
    logic [PG_W-1:0] last_idx;

    // Last count index for the selected granularity.
    always_comb last_idx = PG_W'(gran_pulses(gsel) - 1);

    // Pulse counter and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !div_en) begin
            pg_cnt <= '0;
            tick   <= 1'b0;
        end else if (com_pulse) begin
            tick   <= (pg_cnt >= last_idx);
            pg_cnt <= (pg_cnt >= last_idx) ? '0 : pg_cnt + 1'b1;
        end else begin
            tick <= 1'b0;
        end
    end

    AST_TICK_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(com_pulse)) else $error("tick without pulse"); // R9
    AST_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |=> !tick) else $error("tick while disabled"); // R7

endmodule

// File: rtl/tpu_timer_unit.sv
// Top of the timestamp and pulse timer unit. Holds configuration,
// the wide base counter, three shifted stamp views, the common-clock
// divider and NUM_PG pulse generators.
// Assumes all inputs are synchronous to clk.
module tpu_timer_unit
    import tpu_pkg::*;
#(
    parameter int unsigned CNT_W  = 56,
    parameter int unsigned TS_W   = 32,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned NUM_PG = 3,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned PG_W   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [TS_W-1:0]   legacy_ms_time,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [TS_W-1:0]   stamp_log,
    output logic [TS_W-1:0]   stamp_tag,
    output logic [TS_W-1:0]   stamp_xlat,
    output logic [NUM_PG-1:0] tick_out
);

    localparam int unsigned EXT_W = (CNT_W > TS_W) ? CNT_W : TS_W;

    logic [DIV_W-1:0]                  div_val;
    logic                              div_en;
    logic                              log_sel;
    logic [NUM_STAMP-1:0][SHIFT_W-1:0] shifts;
    logic [NUM_PG-1:0][GSEL_W-1:0]     gsel;
    logic [CNT_W-1:0]                  count;
    logic                              com_pulse;
    logic [NUM_STAMP-1:0][TS_W-1:0]    views;

    tpu_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DIV_W  (DIV_W),
        .NUM_PG (NUM_PG)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .div_val (div_val),
        .div_en  (div_en),
        .log_sel (log_sel),
        .shifts  (shifts),
        .gsel    (gsel)
    );

    tpu_base_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .count    (count)
    );

    generate
        for (genvar s = 0; s < NUM_STAMP; s++) begin : g_view
            logic [EXT_W-1:0] ext;
            // Shifted view of the base count, fitted to TS_W bits.
            always_comb begin
                ext      = EXT_W'(count) >> shifts[s];
                views[s] = ext[TS_W-1:0];
            end
        end
    endgenerate

    // Output selection for the three stamps.
    always_comb begin
        stamp_log  = log_sel ? views[STAMP_LOG] : legacy_ms_time;
        stamp_tag  = views[STAMP_TAG];
        stamp_xlat = views[STAMP_XLAT];
    end

    tpu_xo_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .div_en    (div_en),
        .div_val   (div_val),
        .com_pulse (com_pulse)
    );

    generate
        for (genvar g = 0; g < NUM_PG; g++) begin : g_pg
            tpu_pulse_gen #(
                .PG_W (PG_W)
            ) u_pg (
                .clk       (clk),
                .rst_n     (rst_n),
                .div_en    (div_en),
                .com_pulse (com_pulse),
                .gsel      (gsel[g]),
                .tick      (tick_out[g])
            );
        end
    endgenerate

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (tick_out == '0)) else $error("tick after reset"); // R1

endmodule

// File: tb/tpu_timer_unit_test.sv
`timescale 1ns/1ps
module tpu_timer_unit_test;

    localparam int unsigned CW = 16;
    localparam longint unsigned MASK = (64'd1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [31:0] legacy_ms_time = 32'h0000_0abc;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] stamp_log, stamp_tag, stamp_xlat;
    logic [2:0]  tick_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    longint unsigned exp_cnt = 0;
    int first_j [3];
    int n_ticks [3];

    tpu_timer_unit #(.CNT_W(CW)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ref_tick       (ref_tick),
        .legacy_ms_time (legacy_ms_time),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .stamp_log      (stamp_log),
        .stamp_tag      (stamp_tag),
        .stamp_xlat     (stamp_xlat),
        .tick_out       (tick_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ref_run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = 1'b1;
            exp_cnt = (exp_cnt + 1) & MASK;
        end
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    // Runs ref_tick for m edges starting right after the last write.
    task automatic window(input int m);
        for (int g = 0; g < 3; g++) begin first_j[g] = 0; n_ticks[g] = 0; end
        ref_tick = 1'b1;
        for (int j = 1; j <= m; j++) begin
            @(negedge clk);
            exp_cnt = (exp_cnt + 1) & MASK;
            for (int g = 0; g < 3; g++) begin
                if (tick_out[g]) begin
                    n_ticks[g]++;
                    if (first_j[g] == 0) first_j[g] = j;
                end
            end
        end
        ref_tick = 1'b0;
    endtask

    function automatic logic [31:0] stamp_word(int ls, bit sel, int ts, int xs);
        return 32'(ls) | (32'(sel) << 7) | (32'(ts) << 8) | (32'(xs) << 16);
    endfunction

    function automatic longint unsigned shr(int s);
        return (s >= 64) ? 0 : (exp_cnt >> s);
    endfunction

    task automatic t_reset();
        check("R1 tag", stamp_tag, 0);
        check("R1 xlat", stamp_xlat, 0);
        check("R1 log legacy", stamp_log, legacy_ms_time);
        window(40);
        check("R1 no ticks", n_ticks[0] + n_ticks[1] + n_ticks[2], 0);
    endtask

    task automatic t_count();
        ref_run(37);
        check("R2 count", stamp_tag, exp_cnt);
        repeat (5) @(negedge clk);
        check("R2 hold", stamp_tag, exp_cnt);
    endtask

    task automatic t_shift();
        wr(1, stamp_word(3, 1'b1, 0, 5));
        check("R4 log shift", stamp_log, shr(3));
        check("R4 tag shift", stamp_tag, shr(0));
        check("R4 xlat shift", stamp_xlat, shr(5));
        ref_run(300);
        check("R4 log after run", stamp_log, shr(3));
        check("R4 xlat after run", stamp_xlat, shr(5));
        wr(1, stamp_word(14, 1'b1, 2, 20));
        check("R4 shift 14", stamp_log, shr(14));
        check("R4 tag shift 2", stamp_tag, shr(2));
        check("R4 shift beyond width", stamp_xlat, 0);
    endtask

    task automatic t_legacy();
        wr(1, stamp_word(0, 1'b0, 0, 0));
        check("R5 legacy sel", stamp_log, legacy_ms_time);
        @(negedge clk);
        legacy_ms_time = 32'h5a5a_1234;
        #1;
        check("R5 legacy follows", stamp_log, 32'h5a5a_1234);
        wr(1, stamp_word(0, 1'b1, 0, 0));
        check("R5 counter sel", stamp_log, exp_cnt);
    endtask

    task automatic t_wrap();
        ref_run(int'(MASK - exp_cnt));
        check("R3 all ones", stamp_tag, MASK);
        ref_run(1);
        check("R3 wrapped", stamp_tag, 0);
    endtask

    task automatic t_div();
        wr(2, 32'h0000_0000);
        wr(0, 32'd2);
        wr(0, 32'h8000_0002);
        window(40);
        for (int g = 0; g < 3; g++) begin
            check("R6 first pulse", first_j[g], 4);
            check("R6 count", n_ticks[g], 13);
        end
        wr(0, 32'd2);
    endtask

    task automatic t_mix();
        wr(2, 32'h0000_0210);
        wr(0, 32'd1);
        wr(0, 32'h8000_0001);
        window(60);
        check("R10 gen0 count", n_ticks[0], 29);
        check("R10 gen1 count", n_ticks[1], 14);
        check("R10 gen2 count", n_ticks[2], 5);
        check("R10 gen2 first", first_j[2], 11);
        wr(0, 32'd1);
    endtask

    task automatic t_codes();
        wr(2, 32'h0000_0543);
        wr(0, 32'h8000_0000);
        window(1005);
        check("R9 code3 first", first_j[0], 11);
        check("R9 code4 first", first_j[1], 101);
        check("R9 code5 first", first_j[2], 1001);
        check("R9 code3 count", n_ticks[0], 100);
        check("R9 code4 count", n_ticks[1], 10);
        wr(0, 32'd0);
        wr(2, 32'h0000_0006);
        wr(0, 32'h8000_0000);
        window(10005);
        check("R9 code6 first", first_j[0], 10001);
        wr(0, 32'd0);
    endtask

    task automatic t_disable();
        wr(2, 32'h0000_0000);
        wr(0, 32'd0);
        wr(0, 32'd5);
        window(50);
        check("R7 no ticks disabled", n_ticks[0] + n_ticks[1] + n_ticks[2], 0);
    endtask

    task automatic t_reenable();
        wr(2, 32'h0000_0111);
        wr(0, 32'h8000_0003);
        window(5);
        check("R8 none yet", n_ticks[0], 0);
        wr(0, 32'd3);
        wr(0, 32'h8000_0003);
        window(20);
        check("R8 first after restart", first_j[0], 9);
        check("R8 count after restart", n_ticks[1], 2);
    endtask

    task automatic t_unmapped();
        wr(0, 32'd3);
        wr(1, stamp_word(1, 1'b1, 0, 2));
        wr(3, 32'hffff_ffff);
        wr(4'hf, 32'hffff_ffff);
        window(30);
        check("R11 no ticks", n_ticks[0] + n_ticks[1] + n_ticks[2], 0);
        check("R11 log shift kept", stamp_log, shr(1));
        check("R11 xlat shift kept", stamp_xlat, shr(2));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_shift();
        t_legacy();
        t_wrap();
        t_div();
        t_mix();
        t_codes();
        t_disable();
        t_reenable();
        t_unmapped();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule